// File: doc/BRIEF.md
# Register-Mapped MII Management Port

This block lets host logic reach the registers of external Ethernet PHYs as ordinary mapped words, so no software has to toggle the management clock and data lines. Each pair of PHY address and PHY register number has its own slot in a 10-bit word address. A host write to a slot sends one management write frame on the serial bus. A host read of a slot sends one management read frame, and the 16-bit value that comes back is held on the result port together with a data-valid flag.

Inside the block, a clock divider makes the management clock (MDC) from the system clock. A serial engine builds each frame, drives the data line (MDIO), releases the line for the turnaround and data fields of a read, and shifts in the returned bits. A busy flag covers the whole frame. While busy is high, a new host request is held off by a ready signal.

Top module: `mii_mgmt_map`

## Requirements
- R1: The host word address is split into the PHY address in `acc_addr[9:5]` and the PHY register number in `acc_addr[4:0]`. An access taken with `acc_write`=1 sends a write frame, and one taken with `acc_write`=0 sends a read frame for that pair.
- R2: Every frame is `PRE_LEN` ones (32 by default), then start bits 01, then opcode 01 for a write or 10 for a read, then the 5-bit PHY address and the 5-bit register number, all most significant bit first. A write frame continues with turnaround 10 and the 16 write-data bits, most significant bit first, with `mdio_oe` high for the whole frame.
- R3: In a read frame, `mdio_oe` is high up to the end of the register-number field and low for the turnaround and the 16 data bits. The data bits are sampled on MDC rising edges, most significant bit first, and the result appears on `rd_data`.
- R4: `rd_valid` is 0 in the cycle after a read is accepted. It goes to 1, together with the new `rd_data`, when the last data bit is captured. Both stay unchanged through later write frames until the next read starts.
- R5: If the PHY leaves the data line undriven, so that it is pulled high, a read returns 16'hFFFF.
- R6: An access is accepted on a clock edge where `acc_valid` and `acc_ready` are both high, and `acc_ready` equals the inverse of `busy`. `busy` rises in the cycle after acceptance and stays high for exactly (`PRE_LEN`+32)*2*`DIV_HALF` cycles. A request that arrives while busy is stalled and then carried out unchanged once busy falls.
- R7: MDC is low whenever the block is idle. During a frame, each MDC high phase and each MDC low phase lasts `DIV_HALF` system clocks. `mdio_o` changes only together with a falling edge of MDC.
- R8: After reset, `busy`, `rd_valid`, `mdc` and `mdio_oe` are 0, `acc_ready` is 1, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access request |
| acc_write | input | 1 | 1 = write frame, 0 = read frame |
| acc_addr | input | 10 | {PHY address, register number} |
| acc_wdata | input | 16 | Data for a write frame |
| acc_ready | output | 1 | Access can be accepted this cycle |
| rd_data | output | 16 | Last read result |
| rd_valid | output | 1 | rd_data holds a completed read |
| busy | output | 1 | A frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (pulled high when undriven) |

## Verification
Every result is due at a fixed distance from the clock edge that accepts the access. `busy` and a cleared `rd_valid` must be seen one cycle after acceptance. `busy` must then stay high for exactly (`PRE_LEN`+32)*2*`DIV_HALF` cycles, and `rd_valid` with its data must be present by the first idle cycle. The bench drives inputs and samples outputs on the falling system clock edge. It counts each cycle of a frame from the acceptance edge, counting MDC-high cycles in the same pass, and compares the frame bits, enable pattern and returned data recorded by its PHY model only after `busy` has fallen.

// File: rtl/mdio_map_pkg.sv
package mdio_map_pkg;
   localparam int PHY_AW   = 5;
   localparam int REG_AW   = 5;
   localparam int ADDR_W   = PHY_AW + REG_AW;
   localparam int DATA_W   = 16;
   localparam int HDR_LEN  = 2 + 2 + PHY_AW + REG_AW;   // start, opcode, addresses
   localparam int BODY_LEN = HDR_LEN + 2 + DATA_W;      // plus turnaround and data

   localparam logic [1:0] START_PAT = 2'b01;
   localparam logic [1:0] TA_WRITE  = 2'b10;

   typedef enum logic [1:0] {
      OP_WR = 2'b01,
      OP_RD = 2'b10
   } mdio_op_e;

   typedef struct packed {
      logic              is_read;
      logic [PHY_AW-1:0] phy;
      logic [REG_AW-1:0] regn;
      logic [DATA_W-1:0] wdata;
   } mdio_req_t;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_evt,
   output logic fall_evt
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [CW-1:0] WRAP = CW'(DIV_HALF - 1);

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap     = run && (cnt == WRAP);
   assign rise_evt = wrap && !mdc;
   assign fall_evt = wrap && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // MDC drops to low as soon as the engine stops running
   assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_flops
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2+((STAGES==1)?1:0):0], din};
         end
         assign dout = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_map_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mdio_req_t         req,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              mdio_in,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam int FRAME_LEN = PRE_LEN + BODY_LEN;
   localparam int BW        = $clog2(FRAME_LEN);
   localparam int SW        = $clog2(BODY_LEN);
   localparam logic [BW-1:0] LAST     = BW'(FRAME_LEN - 1);
   localparam logic [BW-1:0] PRE_END  = BW'(PRE_LEN);
   localparam logic [BW-1:0] TA_POS   = BW'(PRE_LEN + HDR_LEN);
   localparam logic [BW-1:0] DATA_POS = BW'(PRE_LEN + HDR_LEN + 2);

   mdio_req_t         cur;
   logic [BW-1:0]     bcnt;
   logic [DATA_W-1:0] rd_shift;
   logic [BODY_LEN-1:0] body;
   logic [SW-1:0]     sel;
   mdio_op_e          op;

   always_comb begin
      op   = cur.is_read ? OP_RD : OP_WR;
      body = {START_PAT, op, cur.phy, cur.regn,
              cur.is_read ? 2'b11 : TA_WRITE,
              cur.is_read ? {DATA_W{1'b1}} : cur.wdata};
      sel  = SW'(LAST - bcnt);
   end

   assign mdio_o  = (!busy || bcnt < PRE_END) ? 1'b1 : body[sel];
   assign mdio_oe = busy && (!cur.is_read || bcnt < TA_POS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         bcnt     <= '0;
         cur      <= '0;
         rd_shift <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         bcnt <= '0;
         cur  <= req;
         if (req.is_read) rd_valid <= 1'b0;
      end else if (busy) begin
         if (rise_evt && cur.is_read && bcnt >= DATA_POS) begin
            rd_shift <= {rd_shift[DATA_W-2:0], mdio_in};
            if (bcnt == LAST) begin
               rd_data  <= {rd_shift[DATA_W-2:0], mdio_in};
               rd_valid <= 1'b1;
            end
         end
         if (fall_evt) begin
            if (bcnt == LAST) begin
               busy <= 1'b0;
               bcnt <= '0;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end
      end
   end

   // the captured request cannot change while its frame runs
   assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(cur));

   // driven data only moves together with an MDC falling event
   assert_out_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && mdio_oe && $past(mdio_oe) && mdio_o != $past(mdio_o))
      |-> $past(fall_evt));

   // a result appears only at the last bit of a read frame
   assert_valid_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> busy && cur.is_read && bcnt == LAST);

   // a frame ends only on an MDC falling event
   assert_end_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(fall_evt));
endmodule

// File: rtl/mii_mgmt_map.sv
module mii_mgmt_map
   import mdio_map_pkg::*;
#(
   parameter int DIV_HALF    = 4,
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              acc_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("PRE_LEN must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES >= DIV_HALF) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0 .. DIV_HALF-1");
      end
   endgenerate

   logic      start;
   logic      rise_evt, fall_evt;
   logic      mdio_s;
   mdio_req_t req;

   assign acc_ready   = !busy;
   assign start       = acc_valid && acc_ready;
   assign req.is_read = !acc_write;
   assign req.phy     = acc_addr[ADDR_W-1:REG_AW];
   assign req.regn    = acc_addr[REG_AW-1:0];
   assign req.wdata   = acc_wdata;

   mdc_divider #(.DIV_HALF(DIV_HALF)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt));

   mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(mdio_i), .dout(mdio_s));

   mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .req(req),
      .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_in(mdio_s),
      .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .rd_data(rd_data), .rd_valid(rd_valid));

   // a frame only begins on a host request
   assert_launch_on_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(acc_valid));

   // MDC never pulses outside a frame
   assert_mdc_within_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> busy);
endmodule

// File: tb/sim_mii_mgmt_map.sv
module sim_mii_mgmt_map;
   localparam int DIV   = 4;
   localparam int PRE   = 32;
   localparam int FRAME = PRE + 32;
   localparam int NCYC  = FRAME * 2 * DIV;
   localparam logic [4:0] MODEL_PHY = 5'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0;
   logic [9:0]  acc_addr = '0;
   logic [15:0] acc_wdata = '0;
   logic acc_ready, rd_valid, busy, mdc, mdio_o, mdio_oe, mdio_i;
   logic [15:0] rd_data;

   always #5 clk = ~clk;

   mii_mgmt_map #(.DIV_HALF(DIV), .PRE_LEN(PRE), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   // PHY model: one responding address, line pulled high when nobody drives
   logic        mdio_drv = 1'b1;
   logic [15:0] phy_regs [32];
   logic [63:0] sr = '0, oesr = '0;
   logic [63:0] fr_bits [8];
   logic [63:0] fr_oe [8];
   int          p = 0, nfr = 0;
   logic        rd_act = 1'b0;
   logic [4:0]  rd_reg = '0;

   assign mdio_i = mdio_oe ? mdio_o : mdio_drv;

   always @(posedge mdc) begin
      sr   = {sr[62:0], mdio_i};
      oesr = {oesr[62:0], mdio_oe};
      p    = p + 1;
      if (p == PRE + 14) begin
         rd_act = (sr[11:10] == 2'b10) && (sr[9:5] == MODEL_PHY);
         rd_reg = sr[4:0];
      end
      if (p == FRAME) begin
         fr_bits[nfr % 8] = sr;
         fr_oe[nfr % 8]   = oesr;
         nfr = nfr + 1;
         if (sr[29:28] == 2'b01 && sr[27:23] == MODEL_PHY) phy_regs[sr[22:18]] = sr[15:0];
         rd_act = 1'b0;
         p = 0;
      end
   end

   always @(negedge mdc) begin
      if (rd_act && p >= PRE + 16 && p < FRAME) mdio_drv = phy_regs[rd_reg][15 - (p - PRE - 16)];
      else mdio_drv = 1'b1;
   end

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   int last_cyc, last_hi;
   logic [15:0] shadow [32];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_frame(input bit we, input logic [9:0] a, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, we ? 2'b01 : 2'b10, a, 2'b10, d};
   endfunction

   function automatic logic [63:0] exp_oe(input bit we);
      return we ? 64'hFFFF_FFFF_FFFF_FFFF : {{(PRE + 14){1'b1}}, 18'b0};
   endfunction

   task automatic access(input bit we, input logic [9:0] a, input logic [15:0] d, input bit wait_done);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = we; acc_addr = a; acc_wdata = d;
      while (!acc_ready) @(negedge clk);
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R6 busy after accept", busy, 1);
      chk("R6 ready low while busy", acc_ready, 0);
      if (!we) chk("R4 valid cleared by read", rd_valid, 0);
      last_cyc = 1; last_hi = mdc;
      if (wait_done) begin
         while (busy) begin
            @(negedge clk);
            if (busy) begin last_cyc++; last_hi += mdc; end
         end
      end
   endtask

   task automatic check_frame(input string tag, input bit we, input logic [9:0] a, input logic [15:0] d);
      logic [63:0] got, exp;
      got = fr_bits[(nfr - 1) % 8];
      exp = exp_frame(we, a, d);
      if (we) chk({tag, " R2 write frame bits"}, got, exp);
      else    chk({tag, " R1 R2 read frame header"}, {got[63:16], 16'h0}, {exp[63:18], got[17:16], 16'h0});
      chk({tag, we ? " R2 write enable" : " R3 read enable"}, fr_oe[(nfr - 1) % 8], exp_oe(we));
   endtask

   initial begin
      logic [15:0] rv;
      logic [4:0]  rg;
      void'($urandom(32'd2024));
      for (int i = 0; i < 32; i++) begin phy_regs[i] = '0; shadow[i] = '0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8 busy", busy, 0);
      chk("R8 ready", acc_ready, 1);
      chk("R8 rd_valid", rd_valid, 0);
      chk("R8 rd_data", rd_data, 0);
      chk("R8 mdc", mdc, 0);
      chk("R8 mdio_oe", mdio_oe, 0);

      // directed write, full timing
      access(1, {MODEL_PHY, 5'd0}, 16'hA5C3, 1);
      shadow[0] = 16'hA5C3;
      chk("R6 frame length", last_cyc, NCYC);
      chk("R7 mdc high cycles", last_hi, FRAME * DIV);
      chk("R7 mdc idle low", mdc, 0);
      chk("R1 frame count", nfr, 1);
      check_frame("w0", 1, {MODEL_PHY, 5'd0}, 16'hA5C3);

      // directed read back
      access(0, {MODEL_PHY, 5'd0}, 16'h0, 1);
      chk("R6 read frame length", last_cyc, NCYC);
      check_frame("r0", 0, {MODEL_PHY, 5'd0}, 16'h0);
      chk("R3 read data", rd_data, 16'hA5C3);
      chk("R4 valid set", rd_valid, 1);

      // a write leaves the result alone
      access(1, {MODEL_PHY, 5'd31}, 16'h0001, 1);
      shadow[31] = 16'h0001;
      chk("R4 valid kept over write", rd_valid, 1);
      chk("R4 data kept over write", rd_data, 16'hA5C3);

      // absent PHY
      access(0, {5'd7, 5'd2}, 16'h0, 1);
      chk("R5 absent PHY all ones", rd_data, 16'hFFFF);
      chk("R5 valid", rd_valid, 1);

      // stall: read queued behind a running write
      access(1, {MODEL_PHY, 5'd9}, 16'h8001, 0);
      shadow[9] = 16'h8001;
      access(0, {MODEL_PHY, 5'd9}, 16'h0, 1);
      chk("R6 stalled read carried out", fr_bits[(nfr - 1) % 8][29:28], 2'b10);
      chk("R6 write before stall", fr_bits[(nfr - 2) % 8][29:28], 2'b01);
      chk("R6 stalled read data", rd_data, 16'h8001);

      // random traffic
      for (int k = 0; k < 20; k++) begin
         rg = 5'($urandom_range(0, 31));
         rv = 16'($urandom);
         access(1, {MODEL_PHY, rg}, rv, 1);
         shadow[rg] = rv;
         check_frame("rand w", 1, {MODEL_PHY, rg}, rv);
         rg = 5'($urandom_range(0, 31));
         if ($urandom_range(0, 3) == 0) begin
            access(0, {5'd20, rg}, 16'h0, 1);
            chk("R5 random absent read", rd_data, 16'hFFFF);
         end else begin
            access(0, {MODEL_PHY, rg}, 16'h0, 1);
            chk("R3 random read data", rd_data, shadow[rg]);
            check_frame("rand r", 0, {MODEL_PHY, rg}, 16'h0);
         end
         chk("R4 random valid", rd_valid, 1);
      end

      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule